// File: doc/BRIEF.md
# Walsh Spectral Test Pattern Synthesizer

This block produces a single stimulus bit-stream for one primary input of a sequential circuit under self-test. A time-step counter feeds an XOR network that yields any row of a Walsh (Hadamard) basis. Three configured rows, each with its own phase, are blended by a random multiplexer tree in fixed shares. A weighted random noise bit is then XORed in, and the result is registered as the pattern bit.

Every pattern bit stays constant for a programmable power-of-two number of system clocks. This number is chosen to match the sequential depth of the circuit under test. The same divider that sets this hold time also paces the time-step counter, so one step of the Walsh counter equals one held vector.

The select and noise bits come from an external weighted random source. They are sampled only on the first cycle of each step. One instance of the block is placed per input of the circuit under test.

Top module: `walsh_pattern_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `pattern` becomes 0. After release, the first rising edge loads the vector of time step 0, and that vector is held for a full step.
- R2: The Walsh row with index k at time step t is the parity of the bitwise AND of k and t. Bit 1 stands for the value -1 and bit 0 stands for +1. The time step counts modulo 2^ORDER_W, which is 8 by default.
- R3: A step lasts 2^h system clocks, where h is `hold_log2` clamped to DIV_W (default 2). `pattern` changes only on the first rising edge of each step.
- R4: When bit i of `comp_phase` is 1, component i is inverted before mixing.
- R5: With `three_way` = 0, component 0 is used when `sel_hi` = 0 and component 1 is used when `sel_hi` = 1. Each component therefore gets half the steps.
- R6: With `three_way` = 1, component 2 is used when `sel_hi` = 0, which gives it a 0.5 share. When `sel_hi` = 1, `sel_lo` picks component 0 (value 0) or component 1 (value 1), giving each a 0.25 share.
- R7: The loaded pattern bit is the mixed component bit XOR `noise`. With `noise` = 1 the bit is inverted.
- R8: `sel_hi`, `sel_lo` and `noise` have no effect on any cycle other than the first cycle of a step.
- R9: The row index of component i is held in `comp_row[i*ORDER_W +: ORDER_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hold_log2 | input | $clog2(DIV_W+1) | Log2 of the number of clocks per held vector |
| comp_row | input | 3*ORDER_W | Walsh row indices of the three components |
| comp_phase | input | 3 | Per-component inversion |
| three_way | input | 1 | 0: two-component mix, 1: three-component mix |
| sel_hi | input | 1 | First-level random select bit, weight 0.5 |
| sel_lo | input | 1 | Second-level random select bit, weight 0.5 |
| noise | input | 1 | Weighted random noise bit |
| pattern | output | 1 | Held test bit for the circuit under test |

## Verification
A wrong divider count or a wrong time-step counter shows up at `pattern` as a vector that changes in the middle of a step or that reappears at the wrong position. This appears within one step when the noise and select inputs are held fixed. A wrong index slice, phase or multiplexer leg produces a bit sequence over eight steps that differs from the expected Walsh row in at least one step. A noise path that samples on the wrong cycle is exposed when the bench changes the random inputs on every clock, because the bit then drifts away from the value sampled at the start of the step.

// File: rtl/walsh_pkg.sv
package walsh_pkg;

  localparam int unsigned NCOMP = 3;
  localparam int unsigned MAXW  = 16;

  // parity of (row AND step): XOR network over a counter
  function automatic logic walsh_bit(input logic [MAXW-1:0] row,
                                     input logic [MAXW-1:0] step);
    return ^(row & step);
  endfunction

  // two-level select tree; c2 carries the half share in three-way mode
  function automatic logic mix_pick(input logic three, input logic hi,
                                    input logic lo, input logic c0,
                                    input logic c1, input logic c2);
    logic leaf;
    if (three) begin
      leaf = lo ? c1 : c0;
      return hi ? leaf : c2;
    end
    return hi ? c1 : c0;
  endfunction

endpackage

// File: rtl/walsh_step_timer.sv
module walsh_step_timer #(
  parameter int unsigned ORDER_W = 3,
  parameter int unsigned DIV_W   = 2,
  parameter int unsigned HW      = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HW-1:0]      hold_log2,
  output logic               load_evt,
  output logic               step_tick,
  output logic [ORDER_W-1:0] step_t,
  output logic [DIV_W-1:0]   div_cnt
);

  localparam logic [DIV_W:0] ONE = (DIV_W+1)'(1);

  logic [DIV_W-1:0]   div_q;
  logic [ORDER_W-1:0] t_q;
  logic [HW-1:0]      h_eff;
  logic [DIV_W:0]     last_cnt;

  always_comb begin
    if (int'(hold_log2) > int'(DIV_W)) h_eff = HW'(DIV_W);
    else                               h_eff = hold_log2;
    last_cnt = (ONE << h_eff) - ONE;
  end

  assign step_tick = ({1'b0, div_q} >= last_cnt);
  assign load_evt  = (div_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      t_q   <= '0;
    end else if (step_tick) begin
      div_q <= '0;
      t_q   <= t_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign step_t  = t_q;
  assign div_cnt = div_q;

endmodule

// File: rtl/walsh_row_bank.sv
module walsh_row_bank
  import walsh_pkg::*;
#(
  parameter int unsigned ORDER_W = 3
) (
  input  logic [ORDER_W-1:0]       step_t,
  input  logic [NCOMP*ORDER_W-1:0] comp_row,
  input  logic [NCOMP-1:0]         comp_phase,
  output logic [NCOMP-1:0]         comp_bits
);

  for (genvar i = 0; i < NCOMP; i++) begin : g_comp
    logic [ORDER_W-1:0] row_i;
    assign row_i        = comp_row[i*ORDER_W +: ORDER_W];
    assign comp_bits[i] = walsh_bit(MAXW'(row_i), MAXW'(step_t)) ^ comp_phase[i];
  end

endmodule

// File: rtl/walsh_mix_noise.sv
module walsh_mix_noise
  import walsh_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load_evt,
  input  logic             three_way,
  input  logic             sel_hi,
  input  logic             sel_lo,
  input  logic             noise,
  input  logic [NCOMP-1:0] comp_bits,
  output logic             mixed_bit,
  output logic             pattern
);

  logic pat_q;

  assign mixed_bit = mix_pick(three_way, sel_hi, sel_lo,
                              comp_bits[0], comp_bits[1], comp_bits[2]);

  always_ff @(posedge clk) begin
    if (rst)           pat_q <= 1'b0;
    else if (load_evt) pat_q <= mixed_bit ^ noise;
  end

  assign pattern = pat_q;

endmodule

// File: rtl/walsh_pattern_gen.sv
module walsh_pattern_gen
  import walsh_pkg::*;
#(
  parameter int unsigned ORDER_W = 3,
  parameter int unsigned DIV_W   = 2,
  localparam int unsigned HW     = $clog2(DIV_W + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [HW-1:0]            hold_log2,
  input  logic [NCOMP*ORDER_W-1:0] comp_row,
  input  logic [NCOMP-1:0]         comp_phase,
  input  logic                     three_way,
  input  logic                     sel_hi,
  input  logic                     sel_lo,
  input  logic                     noise,
  output logic                     pattern
);

  logic               load_evt;
  logic               step_tick;
  logic [ORDER_W-1:0] step_t;
  logic [DIV_W-1:0]   div_cnt;
  logic [NCOMP-1:0]   comp_bits;
  logic               mixed_bit;

  walsh_step_timer #(.ORDER_W(ORDER_W), .DIV_W(DIV_W), .HW(HW)) u_timer (
    .clk(clk), .rst(rst), .hold_log2(hold_log2),
    .load_evt(load_evt), .step_tick(step_tick),
    .step_t(step_t), .div_cnt(div_cnt)
  );

  walsh_row_bank #(.ORDER_W(ORDER_W)) u_rows (
    .step_t(step_t), .comp_row(comp_row),
    .comp_phase(comp_phase), .comp_bits(comp_bits)
  );

  walsh_mix_noise u_mix (
    .clk(clk), .rst(rst), .load_evt(load_evt), .three_way(three_way),
    .sel_hi(sel_hi), .sel_lo(sel_lo), .noise(noise),
    .comp_bits(comp_bits), .mixed_bit(mixed_bit), .pattern(pattern)
  );

endmodule

// File: rtl/walsh_pattern_gen_chk.sv
module walsh_pattern_gen_chk #(
  parameter int unsigned ORDER_W = 3,
  parameter int unsigned DIV_W   = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               load_evt,
  input logic               step_tick,
  input logic [ORDER_W-1:0] step_t,
  input logic [DIV_W-1:0]   div_cnt,
  input logic [2:0]         comp_bits,
  input logic               mixed_bit,
  input logic               three_way,
  input logic               sel_hi,
  input logic               noise,
  input logic               pattern
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (pattern == 1'b0));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !load_evt |=> $stable(pattern));

  // R3
  step_restart_chk: assert property (@(posedge clk) disable iff (rst)
    step_tick |=> (load_evt && div_cnt == '0));

  // R2
  step_advance_chk: assert property (@(posedge clk) disable iff (rst)
    step_tick |=> (step_t == ORDER_W'($past(step_t) + 1'b1)));

  // R2
  step_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !step_tick |=> $stable(step_t));

  // R5
  two_way_leg_chk: assert property (@(posedge clk) disable iff (rst)
    !three_way |-> (mixed_bit == (sel_hi ? comp_bits[1] : comp_bits[0])));

  // R6
  half_share_chk: assert property (@(posedge clk) disable iff (rst)
    (three_way && !sel_hi) |-> (mixed_bit == comp_bits[2]));

  // R7
  noise_xor_chk: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> (pattern == ($past(mixed_bit) ^ $past(noise))));

endmodule

bind walsh_pattern_gen walsh_pattern_gen_chk #(.ORDER_W(ORDER_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .load_evt(load_evt), .step_tick(step_tick),
  .step_t(step_t), .div_cnt(div_cnt), .comp_bits(comp_bits),
  .mixed_bit(mixed_bit), .three_way(three_way), .sel_hi(sel_hi),
  .noise(noise), .pattern(pattern)
);

// File: tb/test_walsh_pattern_gen.sv
`timescale 1ns/1ps
module test_walsh_pattern_gen;

  localparam int ORDER_W = 3;
  localparam int DIV_W   = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] hold_log2 = '0;
  logic [8:0] comp_row = '0;
  logic [2:0] comp_phase = '0;
  logic       three_way = 1'b0;
  logic       sel_hi = 1'b0;
  logic       sel_lo = 1'b0;
  logic       noise = 1'b0;
  logic       pattern;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [31:0] rng = 32'h1357_9bdf;

  always #2 clk = ~clk;

  walsh_pattern_gen #(.ORDER_W(ORDER_W), .DIV_W(DIV_W)) i_walsh_pattern_gen (
    .clk(clk), .rst(rst), .hold_log2(hold_log2), .comp_row(comp_row),
    .comp_phase(comp_phase), .three_way(three_way), .sel_hi(sel_hi),
    .sel_lo(sel_lo), .noise(noise), .pattern(pattern)
  );

  function automatic logic next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng[7];
  endfunction

  // Walsh value by counting common set bits
  function automatic logic ref_walsh(input int k, input int t);
    int ones = 0;
    for (int b = 0; b < ORDER_W; b++)
      if (((k >> b) & 1) == 1 && ((t >> b) & 1) == 1) ones++;
    return logic'(ones % 2);
  endfunction

  function automatic logic ref_bit(input int step, input logic three,
                                   input logic hi, input logic lo, input logic nz);
    int comp;
    int k;
    if (three) comp = hi ? (lo ? 1 : 0) : 2;
    else       comp = hi ? 1 : 0;
    k = int'(comp_row[comp*ORDER_W +: ORDER_W]);
    return ref_walsh(k, step) ^ comp_phase[comp] ^ nz;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pattern=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_cfg(input int h, input logic three, input logic [8:0] rows,
                         input logic [2:0] ph, input bit rnd_sel, input bit rnd_nz,
                         input logic fhi, input logic flo, input logic fnz,
                         input int nsteps, input string tag);
    int per;
    logic exp;
    per = 1 << ((h > DIV_W) ? DIV_W : h);
    @(negedge clk);
    rst = 1'b1;
    hold_log2 = 2'(h);
    three_way = three;
    comp_row = rows;
    comp_phase = ph;
    sel_hi = 1'b1; sel_lo = 1'b1; noise = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(pattern, 1'b0, "R1 reset");
    rst = 1'b0;
    exp = 1'b0;
    for (int c = 0; c < nsteps * per; c++) begin
      sel_hi = rnd_sel ? next_rand() : fhi;
      sel_lo = rnd_sel ? next_rand() : flo;
      noise  = rnd_nz  ? next_rand() : fnz;
      if (c % per == 0)
        exp = ref_bit((c / per) % (1 << ORDER_W), three, sel_hi, sel_lo, noise);
      @(posedge clk);
      @(negedge clk);
      if (c < per)           check(pattern, exp, "R1 first step");
      else if (c % per == 0) check(pattern, exp, tag);
      else                   check(pattern, exp, "R8 hold");
    end
  endtask

  initial begin
    // R2 R4: single component observed directly, all rows, both phases
    for (int k = 0; k < 8; k++)
      for (int p = 0; p < 2; p++)
        run_cfg(0, 1'b0, {3'd0, 3'd0, 3'(k)}, {2'b00, 1'(p)}, 1'b0, 1'b0,
                1'b0, 1'b0, 1'b0, 16, (p == 1) ? "R4 phase" : "R2 walsh row");
    // R9: component 1 field, component 0 set to the complement row
    for (int k = 0; k < 8; k++)
      run_cfg(0, 1'b0, {3'd0, 3'(k), 3'(~k)}, 3'b000, 1'b0, 1'b0,
              1'b1, 1'b0, 1'b0, 16, "R9 field");
    // R3 R8: every hold setting, both modes, inputs toggling every clock
    for (int h = 0; h < 4; h++)
      for (int m = 0; m < 2; m++)
        run_cfg(h, 1'(m), {3'd5, 3'd3, 3'd6}, 3'b010, 1'b1, 1'b1,
                1'b0, 1'b0, 1'b0, 10, "R3 step");
    // R5: two-way mixing, random selects, no noise
    for (int k = 0; k < 8; k++)
      run_cfg(0, 1'b0, {3'd1, 3'(7 - k), 3'(k)}, 3'(k), 1'b1, 1'b0,
              1'b0, 1'b0, 1'b0, 16, "R5 two-way");
    // R6: three-way mixing, random selects, no noise
    for (int k = 0; k < 8; k++)
      run_cfg(1, 1'b1, {3'(k), 3'((k + 3) % 8), 3'((k + 5) % 8)}, 3'(7 - k),
              1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16, "R6 three-way");
    // R7: noise fixed high, then random noise
    run_cfg(0, 1'b1, {3'd7, 3'd2, 3'd4}, 3'b000, 1'b0, 1'b0,
            1'b0, 1'b0, 1'b1, 16, "R7 noise inverts");
    run_cfg(2, 1'b1, {3'd7, 3'd2, 3'd4}, 3'b101, 1'b1, 1'b1,
            1'b0, 1'b0, 1'b0, 16, "R7 noise random");
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule